// File: doc/BRIEF.md
# Next-Interrupt Priority Selector

This block looks at a set of external interrupt sources, each with a pending bit, an enable bit and a 4-bit priority. It picks the one that should be serviced next. A source counts only if it is pending, enabled, and at or above the previous-preempt level. That level belongs to the handler frame that has been interrupted, and hiding sources below it keeps a handler that was preempted from being picked again inside the frame that preempted it. Among the sources that count, the highest priority wins, and a tie goes to the lowest index.

The result appears in a 32-bit "next interrupt" register that software reads. The same access can also commit the result. When the write data has bit 0 set, the context logic receives a one-cycle commit that carries the winner, its priority and the new preemption level. A single read-and-set-immediate access with value 1 therefore returns the winner and commits it as one atomic step. The block also raises a request toward the core only when the winner's priority reaches the current preempt level.

The selection is purely combinational from the source state, so a read returns the winner of that same cycle. The storage of per-source priority and enable bits, and the core's trap entry, are outside this block.

Top module: `next_irq_selector`

## Requirements
- R1: A source is a candidate only when its pending bit and its enable bit are both 1 and its priority is greater than or equal to `prev_preempt_lvl`. Any other source is never reported.
- R2: Among the candidates, the one with the numerically highest priority is selected. When several candidates share that priority, the lowest index is selected.
- R3: `csr_rdata` is laid out as follows. Bits 10:2 hold the selected index. Bit 31 is the no-interrupt flag. Bit 0, bit 1 and bits 30:11 always read as 0, so the update bit reads back as 0.
- R4: When no candidate exists, the index field reads 0 and bit 31 reads 1. When a candidate exists, bit 31 reads 0.
- R5: `irq_req` is 1 only when a candidate exists and the selected priority, extended to 5 bits, is greater than or equal to `preempt_lvl`. The `preempt_lvl` range is 0 to 16, and a value of 16 blocks every source.
- R6: A cycle with `csr_wr_en`=1 and `csr_wdata[0]`=1 produces `commit_valid`=1 for exactly the following cycle. In that cycle, `commit_irq`, `commit_none` and `commit_prio` carry the index, the no-interrupt flag and the priority that were selected in the access cycle.
- R7: `commit_preempt` is set in two ways. When a winner is committed, it equals the larger of (winner priority + 1) and `prev_preempt_lvl`. When a no-interrupt result is committed, it equals `prev_preempt_lvl`, and `commit_irq` and `commit_prio` are 0.
- R8: A write with `csr_wdata[0]`=0, and any cycle without a write, produces no commit. The commit outputs then hold their last values.
- R9: While reset is held, `commit_valid`, `commit_irq`, `commit_prio` and `commit_preempt` are 0 and `commit_none` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pending | input | NUM_SRC | Pending bit per source |
| src_enable | input | NUM_SRC | Enable bit per source |
| src_prio | input | 4*NUM_SRC | Priority per source; source i at bits 4i+3:4i |
| preempt_lvl | input | 5 | Current preemption threshold (0..16) |
| prev_preempt_lvl | input | 4 | Threshold of the preempted frame; hides lower sources |
| csr_wr_en | input | 1 | Write strobe of the next-interrupt register |
| csr_wdata | input | 32 | Write data; bit 0 requests a commit |
| csr_rdata | output | 32 | Next-interrupt register read value |
| irq_req | output | 1 | Selected source may preempt the current level |
| commit_valid | output | 1 | One-cycle commit pulse to the context logic |
| commit_irq | output | 9 | Committed index |
| commit_none | output | 1 | Committed no-interrupt flag |
| commit_prio | output | 4 | Committed priority |
| commit_preempt | output | 5 | New preemption level for the context logic |

## Verification
The case that is hardest to reach from the ports is a commit whose captured values must come from the access cycle and not from the cycle after it. To reach it, the bench changes the pending set on the same falling edge where it drops the write, so an off-by-one capture would report the new winner. The tie-break and the threshold edges are also difficult. They are exercised by placing equal-priority sources at the low and high ends of the vector, and by moving `prev_preempt_lvl` and `preempt_lvl` exactly onto the winning priority and one step past it.

// File: rtl/nis_pkg.sv
package nis_pkg;
  localparam int PRIO_W = 4;
  localparam int IDX_W  = 9;
  localparam int LVL_W  = PRIO_W + 1;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } cand_t;

  // Left operand always holds the lower indices: equal priority keeps it.
  function automatic cand_t pick_cand(cand_t lo, cand_t hi);
    if (hi.vld && (!lo.vld || (hi.prio > lo.prio))) return hi;
    return lo;
  endfunction
endpackage

// File: rtl/nis_mask.sv
module nis_mask
  import nis_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        ena,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         floor_lvl,
  output cand_t [NUM_SRC-1:0]       leaves
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [PRIO_W-1:0] p;
    assign p = prio[k*PRIO_W +: PRIO_W];
    assign leaves[k].vld  = pend[k] & ena[k] & (p >= floor_lvl);
    assign leaves[k].prio = p;
    assign leaves[k].idx  = IDX_W'(k);
  end
endmodule

// File: rtl/nis_tree.sv
module nis_tree
  import nis_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  cand_t [NUM_SRC-1:0] leaves,
  output cand_t               win
);
  localparam int LVLS = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC);
  localparam int PAD  = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int W = PAD >> l;
    cand_t [W-1:0] nodes;
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_n
        if (k < NUM_SRC) begin : g_real
          assign nodes[k] = leaves[k];
        end else begin : g_pad
          assign nodes[k] = '0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_n
        assign nodes[k] = pick_cand(g_lvl[l-1].nodes[2*k], g_lvl[l-1].nodes[2*k+1]);
      end
    end
  end

  assign win = g_lvl[LVLS].nodes[0];
endmodule

// File: rtl/nis_commit.sv
module nis_commit
  import nis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  cand_t             win,
  input  logic [PRIO_W-1:0] floor_lvl,
  output logic              commit_valid,
  output logic [IDX_W-1:0]  commit_irq,
  output logic              commit_none,
  output logic [PRIO_W-1:0] commit_prio,
  output logic [LVL_W-1:0]  commit_preempt
);
  logic              valid_d;
  logic [IDX_W-1:0]  irq_d;
  logic              none_d;
  logic [PRIO_W-1:0] prio_d;
  logic [LVL_W-1:0]  pre_d;
  logic [LVL_W-1:0]  bumped;

  always_comb begin
    bumped  = LVL_W'(win.prio) + LVL_W'(1);
    valid_d = upd;
    irq_d   = commit_irq;
    none_d  = commit_none;
    prio_d  = commit_prio;
    pre_d   = commit_preempt;
    if (upd) begin
      none_d = ~win.vld;
      if (win.vld) begin
        irq_d  = win.idx;
        prio_d = win.prio;
        pre_d  = (bumped > LVL_W'(floor_lvl)) ? bumped : LVL_W'(floor_lvl);
      end else begin
        irq_d  = '0;
        prio_d = '0;
        pre_d  = LVL_W'(floor_lvl);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid   <= 1'b0;
      commit_irq     <= '0;
      commit_none    <= 1'b1;
      commit_prio    <= '0;
      commit_preempt <= '0;
    end else begin
      commit_valid <= valid_d;
      if (upd) begin
        commit_irq     <= irq_d;
        commit_none    <= none_d;
        commit_prio    <= prio_d;
        commit_preempt <= pre_d;
      end
    end
  end

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> commit_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !commit_valid);
  assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (commit_preempt >= LVL_W'($past(floor_lvl))));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(commit_irq) && $stable(commit_preempt));
endmodule

// File: rtl/next_irq_selector.sv
module next_irq_selector
  import nis_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [LVL_W-1:0]          preempt_lvl,
  input  logic [PRIO_W-1:0]         prev_preempt_lvl,
  input  logic                      csr_wr_en,
  input  logic [31:0]               csr_wdata,
  output logic [31:0]               csr_rdata,
  output logic                      irq_req,
  output logic                      commit_valid,
  output logic [IDX_W-1:0]          commit_irq,
  output logic                      commit_none,
  output logic [PRIO_W-1:0]         commit_prio,
  output logic [LVL_W-1:0]          commit_preempt
);
  localparam int SEL_W = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC);

  cand_t [NUM_SRC-1:0] leaves;
  cand_t               win;
  logic [IDX_W-1:0]    shown_idx;
  logic                upd;

  nis_mask #(.NUM_SRC(NUM_SRC)) i_mask (
    .pend      (src_pending),
    .ena       (src_enable),
    .prio      (src_prio),
    .floor_lvl (prev_preempt_lvl),
    .leaves    (leaves)
  );

  nis_tree #(.NUM_SRC(NUM_SRC)) i_tree (
    .leaves (leaves),
    .win    (win)
  );

  assign shown_idx = win.vld ? win.idx : '0;
  assign csr_rdata = {~win.vld, 20'd0, shown_idx, 2'b00};
  assign irq_req   = win.vld && (LVL_W'(win.prio) >= preempt_lvl);
  assign upd       = csr_wr_en & csr_wdata[0];

  nis_commit i_commit (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd            (upd),
    .win            (win),
    .floor_lvl      (prev_preempt_lvl),
    .commit_valid   (commit_valid),
    .commit_irq     (commit_irq),
    .commit_none    (commit_none),
    .commit_prio    (commit_prio),
    .commit_preempt (commit_preempt)
  );

  // Cross-check of the tree result against the raw source inputs.
  logic [PRIO_W-1:0] prio_arr [NUM_SRC];
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_unpack
    assign prio_arr[k] = src_prio[k*PRIO_W +: PRIO_W];
  end
  logic [SEL_W-1:0] sel;
  assign sel = win.idx[SEL_W-1:0];

  assert_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win.vld |-> (src_pending[sel] && src_enable[sel] && (prio_arr[sel] >= prev_preempt_lvl)));
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[30:11] == 20'd0) && (csr_rdata[1:0] == 2'b00));
  assert_none_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31] |-> (csr_rdata[10:2] == '0) && !irq_req);
  assert_commit_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (commit_irq == $past(csr_rdata[10:2])) && (commit_none == $past(csr_rdata[31])));
  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_lvl == LVL_W'(16)) |-> !irq_req);
endmodule

// File: tb/test_next_irq_selector.sv
`timescale 1ns/1ps
module test_next_irq_selector;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pend, ena;
  logic [N*4-1:0] prio;
  logic [4:0]    pre;
  logic [3:0]    ppre;
  logic          wr_en;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          req, cvalid, cnone;
  logic [8:0]    cirq;
  logic [3:0]    cprio;
  logic [4:0]    cpre;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  next_irq_selector #(.NUM_SRC(N)) i_next_irq_selector (
    .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_enable(ena), .src_prio(prio),
    .preempt_lvl(pre), .prev_preempt_lvl(ppre), .csr_wr_en(wr_en), .csr_wdata(wdata),
    .csr_rdata(rdata), .irq_req(req), .commit_valid(cvalid), .commit_irq(cirq),
    .commit_none(cnone), .commit_prio(cprio), .commit_preempt(cpre)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // Reference model from R1..R4
  function automatic logic [31:0] model_rd();
    int best = -1;
    int bp = -1;
    for (int i = 0; i < N; i++) begin
      int p = int'(prio[4*i +: 4]);
      if (pend[i] && ena[i] && p >= int'(ppre) && p > bp) begin
        best = i;
        bp = p;
      end
    end
    if (best < 0) return 32'h8000_0000;
    return 32'(best) << 2;
  endfunction

  task automatic clear_src();
    pend = '0; ena = '0; prio = '0; pre = '0; ppre = '0;
  endtask

  task automatic set_src(input int i, input logic [3:0] p);
    pend[i] = 1'b1; ena[i] = 1'b1; prio[4*i +: 4] = p;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wdata = '0; clear_src();
    #25;
    chk("R9 valid", 32'(cvalid), 32'd0);
    chk("R9 irq",   32'(cirq),   32'd0);
    chk("R9 none",  32'(cnone),  32'd1);
    chk("R9 pre",   32'(cpre),   32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_mask();
    @(negedge clk); clear_src();
    set_src(3, 4'd9); ena[3] = 1'b0;      // not enabled
    set_src(5, 4'd8); pend[5] = 1'b0;     // not pending
    set_src(9, 4'd2);                     // below floor
    set_src(12, 4'd4);                    // at floor
    ppre = 4'd4;
    #2 chk("R1 masked", rdata, model_rd());
    chk("R1 idx12", 32'(rdata[10:2]), 32'd12);
    ppre = 4'd5;
    #2 chk("R1 floor hides", rdata, 32'h8000_0000);
  endtask

  task automatic t_priority();
    @(negedge clk); clear_src();
    set_src(2, 4'd6); set_src(30, 4'd11); set_src(17, 4'd11); set_src(31, 4'd3);
    #2 chk("R2 tie lowest", 32'(rdata[10:2]), 32'd17);
    chk("R3 layout", rdata, 32'd17 << 2);
    set_src(0, 4'd11);
    #2 chk("R2 tie idx0", rdata, model_rd());
    set_src(31, 4'd15);
    #2 chk("R2 highest", 32'(rdata[10:2]), 32'd31);
  endtask

  task automatic t_none();
    @(negedge clk); clear_src();
    #2 chk("R4 none", rdata, 32'h8000_0000);
    chk("R4 no req", 32'(req), 32'd0);
  endtask

  task automatic t_gate();
    @(negedge clk); clear_src();
    set_src(6, 4'd7); pre = 5'd7;
    #2 chk("R5 equal", 32'(req), 32'd1);
    pre = 5'd8;
    #2 chk("R5 above", 32'(req), 32'd0);
    set_src(6, 4'd15); pre = 5'd15;
    #2 chk("R5 max", 32'(req), 32'd1);
    pre = 5'd16;
    #2 chk("R5 blocked", 32'(req), 32'd0);
    chk("R5 still shown", 32'(rdata[10:2]), 32'd6);
  endtask

  task automatic t_commit();
    @(negedge clk); clear_src();
    set_src(7, 4'd9); ppre = 4'd3;
    wr_en = 1'b1; wdata = 32'h1;
    #2 chk("R3 update reads 0", 32'(rdata[0]), 32'd0);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    set_src(20, 4'd14);                  // changes winner after the access
    #2 chk("R6 valid", 32'(cvalid), 32'd1);
    chk("R6 irq", 32'(cirq), 32'd7);
    chk("R6 prio", 32'(cprio), 32'd9);
    chk("R6 none", 32'(cnone), 32'd0);
    chk("R7 preempt", 32'(cpre), 32'd10);
    @(negedge clk);
    #2 chk("R6 one cycle", 32'(cvalid), 32'd0);
    chk("R8 hold irq", 32'(cirq), 32'd7);
  endtask

  task automatic t_commit_none();
    @(negedge clk); clear_src();
    set_src(4, 4'd2); ppre = 4'd5;
    wr_en = 1'b1; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    #2 chk("R7 none flag", 32'(cnone), 32'd1);
    chk("R7 none irq", 32'(cirq), 32'd0);
    chk("R7 none prio", 32'(cprio), 32'd0);
    chk("R7 none preempt", 32'(cpre), 32'd5);
    @(negedge clk); clear_src();
    set_src(1, 4'd15); ppre = 4'd15;
    wr_en = 1'b1; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    #2 chk("R7 top preempt", 32'(cpre), 32'd16);
  endtask

  task automatic t_no_commit();
    @(negedge clk); clear_src();
    set_src(11, 4'd6);
    wr_en = 1'b1; wdata = 32'hFFFF_FFFE;
    @(negedge clk); wr_en = 1'b0; wdata = 32'h1;   // data without strobe
    #2 chk("R8 no pulse", 32'(cvalid), 32'd0);
    chk("R8 irq kept", 32'(cirq), 32'd1);
    chk("R8 pre kept", 32'(cpre), 32'd16);
    @(negedge clk);
    #2 chk("R8 idle", 32'(cvalid), 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_mask();
        t_priority();
        t_none();
        t_gate();
        t_commit();
        t_commit_none();
        t_no_commit();
      end
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule